// File: doc/BRIEF.md
# Register-Mapped Six-Pin I/O Port

This block is a general purpose I/O port that software reaches over a narrow address/data register bus. Each pin has an output latch bit, a direction bit, an analog-select bit that turns off the pin's digital input buffer, a weak pull-up enable bit and an input-level select bit. The block drives an output-enable, an output value, a pull-up enable, a level-select and a digital-buffer enable for every pin. It samples the incoming pin levels through a synchronizer.

There are two addresses that write the same output latch. The pin address and the latch address both update it. On a read they differ. The latch address returns what the port is driving. The pin address returns the synchronized levels seen on the pins, with pins in analog mode forced to zero. Reads are combinational from the address. Writes take effect at the next rising clock edge.

The pin count, the data width, the synchronizer depth, and whether the pull-up and level registers are built are all parameters. Register map (3-bit address): 0 = pin levels, 1 = output latch, 2 = direction, 3 = analog select, 4 = pull-up enable, 5 = input level. Addresses 6 and 7 are unmapped.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every direction and analog-select bit is 1, and the latch, pull-up and level registers are 0. This gives pin_oe = 0, pin_out = 0 and pin_dig_en = 0. A read of address 2 or address 3 returns 0x3F.
- R2: A write to address 0 (pin levels) loads the output latch. pin_out and a read of address 1 show the written value after the next rising edge.
- R3: A write to address 1 (output latch) loads the same latch, with the same timing as R2.
- R4: A read of address 1 returns the latch contents whatever levels are present on pin_in.
- R5: A read of address 0 returns pin_in delayed by two rising clock edges. A level that has passed only one edge is not yet visible.
- R6: A pin whose analog-select bit is 1 reads as 0 at address 0. Its pin_dig_en bit is 0, and the pin_dig_en bit is 1 when the analog-select bit is 0.
- R7: Direction bit 1 means input and 0 means output. pin_oe is the inverse of the direction register, so writing 0x38 to address 2 makes pins 2..0 outputs (pin_oe = 0x07).
- R8: pin_pu_en for a pin is 1 only when its pull-up bit (address 4) is 1 and the pin is an input.
- R9: pin_lvl_sel follows the level register at address 5, and the register reads back at address 5.
- R10: Write data bits above the pin count are ignored and read back as 0. A write to an unmapped address (6 or 7) changes no output, and a read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| pin_in | input | 6 | Levels sampled from the pins |
| pin_oe | output | 6 | Output enable per pin |
| pin_out | output | 6 | Output value per pin |
| pin_pu_en | output | 6 | Weak pull-up enable per pin |
| pin_lvl_sel | output | 6 | Input-level select per pin |
| pin_dig_en | output | 6 | Digital input buffer enable per pin |

## Verification
The assertions assume bus_wr is a single-cycle strobe, with bus_addr and bus_wdata held stable around the rising edge at which they are sampled. They also assume the outputs can change only in the cycle after a write. The bench drives every bus and pin input at the falling edge and holds it for a full cycle, so the inputs never change near a sampling edge. It raises bus_wr for exactly one cycle per access, which keeps the "no write, no change" property true between accesses. Pin levels are changed only at a falling edge, so the two-edge latency can be counted exactly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int GPIO_ADDR_W = 3;

   typedef enum logic [GPIO_ADDR_W-1:0] {
      REG_PINS   = 3'd0,
      REG_LATCH  = 3'd1,
      REG_DIR    = 3'd2,
      REG_ANALOG = 3'd3,
      REG_PULLUP = 3'd4,
      REG_LEVEL  = 3'd5
   } gpio_reg_e;

   typedef struct packed {
      logic write;
      logic [GPIO_ADDR_W-1:0] addr;
   } gpio_bus_cmd_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int NUM_PINS = 6,
   parameter int STAGES   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] async_in,
   output logic [NUM_PINS-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_in_sync: STAGES must be at least 2");
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_in[p]};
      end
      assign sync_out[p] = chain_q[STAGES-1];
   end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_pkg::*;
#(
   parameter int NUM_PINS   = 6,
   parameter int DATA_W     = 8,
   parameter bit HAS_PULLUP = 1'b1,
   parameter bit HAS_LEVEL  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  gpio_bus_cmd_t       cmd,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] latch_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] ana_q,
   output logic [NUM_PINS-1:0] pu_q,
   output logic [NUM_PINS-1:0] lvl_q
);
   logic [NUM_PINS-1:0] wpins;
   logic unused_wdata;
   assign wpins        = wdata[NUM_PINS-1:0];
   assign unused_wdata = ^wdata;

   logic wr_latch, wr_dir, wr_ana, wr_pu, wr_lvl;
   always_comb begin
      wr_latch = 1'b0;
      wr_dir   = 1'b0;
      wr_ana   = 1'b0;
      wr_pu    = 1'b0;
      wr_lvl   = 1'b0;
      if (cmd.write) begin
         case (cmd.addr)
            REG_PINS, REG_LATCH: wr_latch = 1'b1;
            REG_DIR:             wr_dir   = 1'b1;
            REG_ANALOG:          wr_ana   = 1'b1;
            REG_PULLUP:          wr_pu    = 1'b1;
            REG_LEVEL:           wr_lvl   = 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= '0;
         dir_q   <= '1;
         ana_q   <= '1;
      end else begin
         if (wr_latch) latch_q <= wpins;
         if (wr_dir)   dir_q   <= wpins;
         if (wr_ana)   ana_q   <= wpins;
      end
   end

   if (HAS_PULLUP) begin : g_pullup
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     pu_q <= '0;
         else if (wr_pu) pu_q <= wpins;
      end
   end else begin : g_no_pullup
      logic unused_pu;
      assign unused_pu = wr_pu;
      assign pu_q = '0;
   end

   if (HAS_LEVEL) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      lvl_q <= '0;
         else if (wr_lvl) lvl_q <= wpins;
      end
   end else begin : g_no_level
      logic unused_lvl;
      assign unused_lvl = wr_lvl;
      assign lvl_q = '0;
   end

   // R7: the direction register takes the low write bits
   a_r7_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.write && cmd.addr == REG_DIR) |=> dir_q == $past(wpins));

   // R1: the direction and analog registers can change only after a write
   a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd.write |=> ($stable(dir_q) && $stable(ana_q)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
   import gpio_pkg::*;
#(
   parameter int NUM_PINS = 6,
   parameter int DATA_W   = 8
) (
   input  logic [GPIO_ADDR_W-1:0] addr,
   input  logic [NUM_PINS-1:0]    pins_sync,
   input  logic [NUM_PINS-1:0]    latch_q,
   input  logic [NUM_PINS-1:0]    dir_q,
   input  logic [NUM_PINS-1:0]    ana_q,
   input  logic [NUM_PINS-1:0]    pu_q,
   input  logic [NUM_PINS-1:0]    lvl_q,
   output logic [DATA_W-1:0]      rdata
);
   logic [NUM_PINS-1:0] sel;
   always_comb begin
      case (addr)
         REG_PINS:   sel = pins_sync & ~ana_q;
         REG_LATCH:  sel = latch_q;
         REG_DIR:    sel = dir_q;
         REG_ANALOG: sel = ana_q;
         REG_PULLUP: sel = pu_q;
         REG_LEVEL:  sel = lvl_q;
         default:    sel = '0;
      endcase
      rdata = '0;
      rdata[NUM_PINS-1:0] = sel;
   end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
   import gpio_pkg::*;
#(
   parameter int NUM_PINS    = 6,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PULLUP  = 1'b1,
   parameter bit HAS_LEVEL   = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_wr,
   input  logic [GPIO_ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0]      bus_wdata,
   output logic [DATA_W-1:0]      bus_rdata,
   input  logic [NUM_PINS-1:0]    pin_in,
   output logic [NUM_PINS-1:0]    pin_oe,
   output logic [NUM_PINS-1:0]    pin_out,
   output logic [NUM_PINS-1:0]    pin_pu_en,
   output logic [NUM_PINS-1:0]    pin_lvl_sel,
   output logic [NUM_PINS-1:0]    pin_dig_en
);
   if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
      $error("gpio_port_ctrl: NUM_PINS must be between 1 and DATA_W");
   end

   gpio_bus_cmd_t       cmd;
   logic [NUM_PINS-1:0] latch_q, dir_q, ana_q, pu_q, lvl_q, pins_sync;

   assign cmd.write = bus_wr;
   assign cmd.addr  = bus_addr;

   gpio_regfile #(
      .NUM_PINS(NUM_PINS), .DATA_W(DATA_W),
      .HAS_PULLUP(HAS_PULLUP), .HAS_LEVEL(HAS_LEVEL)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(bus_wdata),
      .latch_q(latch_q), .dir_q(dir_q), .ana_q(ana_q),
      .pu_q(pu_q), .lvl_q(lvl_q)
   );

   gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_sync)
   );

   gpio_read_mux #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) rmux_i (
      .addr(bus_addr), .pins_sync(pins_sync), .latch_q(latch_q),
      .dir_q(dir_q), .ana_q(ana_q), .pu_q(pu_q), .lvl_q(lvl_q),
      .rdata(bus_rdata)
   );

   assign pin_out     = latch_q;
   assign pin_oe      = ~dir_q;
   assign pin_pu_en   = pu_q & dir_q;
   assign pin_lvl_sel = lvl_q;
   assign pin_dig_en  = ~ana_q;

   // R2: a pin-address write lands in the output latch
   a_r2_pins_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_PINS) |=> pin_out == $past(bus_wdata[NUM_PINS-1:0]));

   // R3: a latch-address write lands in the same latch
   a_r3_latch_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_LATCH) |=> pin_out == $past(bus_wdata[NUM_PINS-1:0]));

   // R7: the port-level output enable follows a direction write
   a_r7_oe_after_dir: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_DIR) |=> pin_oe == ~$past(bus_wdata[NUM_PINS-1:0]));

   // R8: no pull-up is enabled on a pin that drives
   a_r8_pu_not_on_output: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_pu_en & pin_oe) == '0);

   // R10: without a write, the driven values stay put
   a_r10_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] pin_in = '0;
   logic [5:0] pin_oe, pin_out, pin_pu_en, pin_lvl_sel, pin_dig_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   gpio_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu_en(pin_pu_en),
      .pin_lvl_sel(pin_lvl_sel), .pin_dig_en(pin_dig_en)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic test_reset();
      logic [7:0] d;
      check("R1 oe", {2'b0, pin_oe}, 8'h00);
      check("R1 out", {2'b0, pin_out}, 8'h00);
      check("R1 dig_en", {2'b0, pin_dig_en}, 8'h00);
      check("R1 pu_en", {2'b0, pin_pu_en}, 8'h00);
      bus_read(3'd2, d); check("R1 dir read", d, 8'h3F);
      bus_read(3'd3, d); check("R1 analog read", d, 8'h3F);
      bus_read(3'd1, d); check("R1 latch read", d, 8'h00);
   endtask

   task automatic test_direction();
      logic [7:0] d;
      bus_write(3'd2, 8'h38);
      check("R7 oe", {2'b0, pin_oe}, 8'h07);
      bus_read(3'd2, d); check("R7 dir read", d, 8'h38);
   endtask

   task automatic test_latch_paths();
      logic [7:0] d;
      bus_write(3'd0, 8'h15);
      check("R2 out", {2'b0, pin_out}, 8'h15);
      bus_read(3'd1, d); check("R2 latch read", d, 8'h15);
      bus_write(3'd1, 8'h2A);
      check("R3 out", {2'b0, pin_out}, 8'h2A);
      bus_read(3'd1, d); check("R3 latch read", d, 8'h2A);
      pin_in = 6'h3F;
      repeat (3) @(negedge clk);
      bus_read(3'd1, d); check("R4 latch ignores pins", d, 8'h2A);
   endtask

   task automatic test_sync();
      logic [7:0] d;
      bus_write(3'd3, 8'h00);
      @(negedge clk); pin_in = 6'h00;
      repeat (3) @(negedge clk);
      bus_read(3'd0, d); check("R5 settled zero", d, 8'h00);
      pin_in = 6'h2D;
      @(negedge clk);
      bus_read(3'd0, d); check("R5 one edge not visible", d, 8'h00);
      @(negedge clk);
      bus_read(3'd0, d); check("R5 two edges visible", d, 8'h2D);
      check("R6 dig_en all on", {2'b0, pin_dig_en}, 8'h3F);
   endtask

   task automatic test_analog();
      logic [7:0] d;
      bus_write(3'd3, 8'h05);
      bus_read(3'd0, d); check("R6 analog pins read 0", d, 8'h28);
      check("R6 dig_en", {2'b0, pin_dig_en}, 8'h3A);
   endtask

   task automatic test_pullup();
      bus_write(3'd2, 8'h38);
      bus_write(3'd4, 8'h3F);
      check("R8 pu on inputs only", {2'b0, pin_pu_en}, 8'h38);
      bus_write(3'd2, 8'h00);
      check("R8 pu off when all outputs", {2'b0, pin_pu_en}, 8'h00);
   endtask

   task automatic test_level();
      logic [7:0] d;
      bus_write(3'd5, 8'h12);
      check("R9 lvl_sel", {2'b0, pin_lvl_sel}, 8'h12);
      bus_read(3'd5, d); check("R9 level read", d, 8'h12);
   endtask

   task automatic test_ignored();
      logic [7:0] d;
      bus_write(3'd1, 8'hC1);
      bus_read(3'd1, d); check("R10 upper bits dropped", d, 8'h01);
      bus_write(3'd7, 8'hFF);
      bus_write(3'd6, 8'hFF);
      check("R10 out unchanged", {2'b0, pin_out}, 8'h01);
      check("R10 oe unchanged", {2'b0, pin_oe}, 8'h3F);
      check("R10 pu unchanged", {2'b0, pin_pu_en}, 8'h00);
      check("R10 lvl unchanged", {2'b0, pin_lvl_sel}, 8'h12);
      bus_read(3'd7, d); check("R10 unmapped read 7", d, 8'h00);
      bus_read(3'd6, d); check("R10 unmapped read 6", d, 8'h00);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_direction();
      test_latch_paths();
      test_sync();
      test_analog();
      test_pullup();
      test_level();
      test_ignored();
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule